// File: doc/BRIEF.md
# Software-Clocked Serial EEPROM Slave

This block models a 256-byte two-wire serial EEPROM whose bus is driven by software rather than by a free-running clock. A host writes new clock-line and data-line levels through a write strobe. The block compares each new pair of levels with the pair it saw on the previous strobe. From that comparison it detects bus conditions and rising clock edges. It then steps a bit counter through a command phase, an acknowledge, an address or data phase and a second acknowledge.

The host reads the data line back through a one-bit registered output. Between strobes the memory contents never change. They are filled through a synchronous load port, which writes only while the block is held in reset. Page writes and programming of the array over the bus are not supported.

A typical random read runs in two parts. The host first sends a write command byte followed by an address byte. It then issues a repeated start, sends a read command byte, and clocks eight bits out of the block.

Top module: `i2cee_slave`

## Requirements
- R1: After reset the read-back output `sda_rd` is 1 (released). A clock cycle without `wr_en` leaves `sda_rd` unchanged.
- R2: A strobe in which SCL is high on both the old and the new sample and SDA changes is a bus condition. SDA falling is a start, which arms the block to receive a command. SDA rising is a stop, which returns the block to idle. Both clear any pending acknowledge.
- R3: While idle (no start since reset or since the last stop, and no acknowledge pending), clock and data activity other than a start or stop produces no acknowledge.
- R4: A data bit is taken only on a strobe where SCL rises from 0 to 1 and SDA keeps its previous level. A rising edge in which SDA also changes is ignored, and the bit count stays where it was.
- R5: After a start, the first 8 accepted bits form the command byte, most significant bit first. Its last bit (bit 0) selects read (1) or write (0). After the 8th bit an acknowledge is pending.
- R6: With a write command, the next 8 accepted bits form the byte address, MSB first. After the 8th of these, the data register is loaded from memory at that address and an acknowledge is pending.
- R7: With a read command, each of the next 8 accepted rising edges drives `sda_rd` with the next bit of the data register, MSB first. The data register then reloads from the current address, and an acknowledge is pending.
- R8: A pending acknowledge is consumed by the next SCL rising edge, which drives `sda_rd` to 0.
- R9: Once the final acknowledge of a transfer has been consumed, further rising edges have no effect until the next start or stop. `sda_rd` then follows the host's SDA.
- R10: The load port writes `ld_data` into memory at `ld_addr` on a clock edge with `ld_en` high, but only while `rst_n` is low. Loads outside reset have no effect.
- R11: Every strobe that is not an acknowledge or read-bit rising edge copies the host's new SDA level into `sda_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Strobe: a new SCL/SDA level pair is present |
| wr_scl | input | 1 | New SCL level written by the host |
| wr_sda | input | 1 | New SDA level written by the host |
| sda_rd | output | 1 | Registered SDA level the host reads back |
| ld_en | input | 1 | Memory preload enable (effective in reset only) |
| ld_addr | input | WORD_W | Memory preload address |
| ld_data | input | WORD_W | Memory preload data |

## Verification
On every cycle, the assertions check the following:
- how bus conditions set the bit counter and the acknowledge flag;
- that idle activity leaves the block idle;
- that rising edges with a changing data line and low-clock strobes never move the counter;
- that a consumed acknowledge pulls the read-back low;
- that ordinary strobes copy the host level;
- that the counter never passes its final value.

Some behaviour can only be shown by the bench's scenarios, because it depends on memory contents and on whole transfers:
- that a full write-address then read-command transfer returns the right stored byte for every address;
- that the acknowledges fall on the right bit positions;
- that loads after reset leave memory untouched.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

   // Per-strobe view of the two bus lines relative to the previous sample
   typedef struct packed {
      logic valid;   // strobe present
      logic start;   // SDA fell while SCL stayed high
      logic stop;    // SDA rose while SCL stayed high
      logic rise;    // SCL went 0 -> 1
      logic steady;  // SDA equal to previous sample
      logic sda;     // new SDA level
   } line_evt_t;

   // Bit counter must reach 2*w+1
   function automatic int tick_bits(input int w);
      return $clog2(2 * w + 2);
   endfunction

endpackage

// File: rtl/i2cee_line_sampler.sv
module i2cee_line_sampler
   import i2cee_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  logic      wr_scl,
   input  logic      wr_sda,
   output line_evt_t evt,
   output logic      scl_q,
   output logic      sda_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else if (wr_en) begin
         scl_q <= wr_scl;
         sda_q <= wr_sda;
      end
   end

   always_comb begin
      evt.valid  = wr_en;
      evt.start  = wr_en & scl_q & wr_scl & sda_q & ~wr_sda;
      evt.stop   = wr_en & scl_q & wr_scl & ~sda_q & wr_sda;
      evt.rise   = wr_en & ~scl_q & wr_scl;
      evt.steady = (sda_q == wr_sda);
      evt.sda    = wr_sda;
   end

endmodule

// File: rtl/i2cee_store.sv
module i2cee_store #(
   parameter int WORD_W = 8,
   parameter int DEPTH  = 256
) (
   input  logic              clk,
   input  logic              ld_we,
   input  logic [WORD_W-1:0] ld_addr,
   input  logic [WORD_W-1:0] ld_data,
   input  logic [WORD_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [WORD_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]  wr_idx;
   logic [IDX_W-1:0]  rd_idx;

   generate
      if (IDX_W == WORD_W) begin : g_full_decode
         assign wr_idx = ld_addr;
         assign rd_idx = rd_addr;
      end else begin : g_wrap_decode
         // Smaller array: address wraps on the low bits
         assign wr_idx = ld_addr[IDX_W-1:0];
         assign rd_idx = rd_addr[IDX_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (ld_we) begin
         mem[wr_idx] <= ld_data;
      end
   end

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/i2cee_seq.sv
module i2cee_seq
   import i2cee_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  line_evt_t                      evt,
   input  logic [WORD_W-1:0]              rd_data,
   output logic [WORD_W-1:0]              fetch_addr,
   output logic [tick_bits(WORD_W)-1:0]   tick,
   output logic                           ack,
   output logic                           sda_o
);

   localparam int TICK_W = tick_bits(WORD_W);
   localparam logic [TICK_W-1:0] T_ONE      = TICK_W'(1);
   localparam logic [TICK_W-1:0] T_CMD_LAST = TICK_W'(WORD_W);
   localparam logic [TICK_W-1:0] T_CMD_END  = TICK_W'(WORD_W + 1);
   localparam logic [TICK_W-1:0] T_END      = TICK_W'(2 * WORD_W + 1);
   localparam logic [TICK_W-1:0] T_DAT_LAST = TICK_W'(2 * WORD_W);

   logic              rd_mode, rd_mode_n;
   logic [WORD_W-1:0] addr, addr_n;
   logic [WORD_W-1:0] data, data_n;
   logic [TICK_W-1:0] tick_n;
   logic              ack_n, sda_n;

   always_comb begin
      tick_n    = tick;
      ack_n     = ack;
      rd_mode_n = rd_mode;
      addr_n    = addr;
      data_n    = data;
      sda_n     = sda_o;
      if (evt.valid) begin
         sda_n = evt.sda;
         if (evt.start) begin
            tick_n = T_ONE;
            ack_n  = 1'b0;
         end else if (evt.stop) begin
            tick_n = '0;
            ack_n  = 1'b0;
         end else if (tick == '0 && !ack) begin
            // idle: wait for a start
         end else if (evt.rise) begin
            if (ack) begin
               ack_n = 1'b0;
               sda_n = 1'b0;
            end else if (evt.steady) begin
               if (tick < T_CMD_END) begin
                  // last bit shifted in is the command LSB: read/write
                  rd_mode_n = evt.sda;
                  tick_n    = tick + T_ONE;
                  if (tick == T_CMD_LAST) begin
                     ack_n = 1'b1;
                  end
               end else if (tick < T_END) begin
                  if (rd_mode) begin
                     sda_n  = data[WORD_W-1];
                     data_n = {data[WORD_W-2:0], 1'b0};
                  end else begin
                     addr_n = {addr[WORD_W-2:0], evt.sda};
                  end
                  tick_n = tick + T_ONE;
                  if (tick == T_DAT_LAST) begin
                     data_n = rd_data;
                     ack_n  = 1'b1;
                  end
               end
            end
         end
      end
   end

   assign fetch_addr = addr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick    <= '0;
         ack     <= 1'b0;
         rd_mode <= 1'b0;
         addr    <= '0;
         data    <= '0;
         sda_o   <= 1'b1;
      end else begin
         tick    <= tick_n;
         ack     <= ack_n;
         rd_mode <= rd_mode_n;
         addr    <= addr_n;
         data    <= data_n;
         sda_o   <= sda_n;
      end
   end

endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
   import i2cee_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int DEPTH  = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_scl,
   input  logic              wr_sda,
   output logic              sda_rd,
   input  logic              ld_en,
   input  logic [WORD_W-1:0] ld_addr,
   input  logic [WORD_W-1:0] ld_data
);

   localparam int TICK_W = tick_bits(WORD_W);

   generate
      if (WORD_W < 2 || WORD_W > 10) begin : g_bad_width
         $error("i2cee_slave: WORD_W must be within 2..10");
      end
      if (DEPTH < 2 || DEPTH > (1 << WORD_W) || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("i2cee_slave: DEPTH must be a power of two no larger than 2**WORD_W");
      end
   endgenerate

   line_evt_t         evt_w;
   logic              scl_q_w, sda_q_w;
   logic [WORD_W-1:0] fetch_addr_w, rd_data_w;
   logic [TICK_W-1:0] tick_w;
   logic              ack_w;
   logic              ld_we_w;

   assign ld_we_w = ld_en & ~rst_n;

   i2cee_line_sampler u_sampler (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_scl (wr_scl),
      .wr_sda (wr_sda),
      .evt    (evt_w),
      .scl_q  (scl_q_w),
      .sda_q  (sda_q_w)
   );

   i2cee_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .ld_we   (ld_we_w),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .rd_addr (fetch_addr_w),
      .rd_data (rd_data_w)
   );

   i2cee_seq #(.WORD_W(WORD_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt_w),
      .rd_data    (rd_data_w),
      .fetch_addr (fetch_addr_w),
      .tick       (tick_w),
      .ack        (ack_w),
      .sda_o      (sda_rd)
   );

endmodule

// File: rtl/i2cee_slave_chk.sv
module i2cee_slave_chk
   import i2cee_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         wr_en,
   input logic                         wr_scl,
   input logic                         wr_sda,
   input logic                         sda_rd,
   input logic                         scl_q,
   input logic                         sda_q,
   input logic [tick_bits(WORD_W)-1:0] tick,
   input logic                         ack
);

   localparam int TICK_W = tick_bits(WORD_W);
   localparam logic [TICK_W-1:0] T_END = TICK_W'(2 * WORD_W + 1);

   // R1
   sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(sda_rd));

   // R2
   start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && scl_q && wr_scl && sda_q && !wr_sda) |=> (tick == TICK_W'(1) && !ack));

   // R2
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && scl_q && wr_scl && !sda_q && wr_sda) |=> (tick == '0 && !ack));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tick == '0 && !ack && !(scl_q && wr_scl && (sda_q != wr_sda)))
      |=> (tick == '0 && !ack));

   // R4
   glitch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !ack && !scl_q && wr_scl && (sda_q != wr_sda)) |=> $stable(tick));

   // R4
   low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_scl) |=> $stable(tick));

   // R8
   ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ack && !scl_q && wr_scl) |=> (!sda_rd && !ack));

   // R9
   tick_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick <= T_END);

   // R11
   host_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(!scl_q && wr_scl)) |=> (sda_rd == $past(wr_sda)));

endmodule

bind i2cee_slave i2cee_slave_chk #(.WORD_W(WORD_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .wr_scl (wr_scl),
   .wr_sda (wr_sda),
   .sda_rd (sda_rd),
   .scl_q  (scl_q_w),
   .sda_q  (sda_q_w),
   .tick   (tick_w),
   .ack    (ack_w)
);

// File: tb/i2cee_slave_bench.sv
module i2cee_slave_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0, wr_scl = 1'b1, wr_sda = 1'b1;
   logic         sda_rd;
   logic         ld_en = 1'b0;
   logic [W-1:0] ld_addr = '0, ld_data = '0;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   i2cee_slave #(.WORD_W(W), .DEPTH(256)) u_i2cee_slave (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_scl(wr_scl), .wr_sda(wr_sda),
      .sda_rd(sda_rd), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
   );

   function automatic logic [W-1:0] pattern(input int a);
      return W'((a * 29 + 7) ^ (a >> 3));
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic c, input logic d);
      @(negedge clk);
      wr_en = 1'b1; wr_scl = c; wr_sda = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic send_bit(input logic b, output logic r);
      strobe(1'b0, b);
      strobe(1'b1, b);
      r = sda_rd;
      strobe(1'b0, b);
   endtask

   task automatic send_byte(input logic [W-1:0] v);
      logic r;
      for (int i = W - 1; i >= 0; i--) send_bit(v[i], r);
   endtask

   task automatic do_start();
      strobe(1'b0, 1'b1);
      strobe(1'b1, 1'b1);
      strobe(1'b1, 1'b0);
      strobe(1'b0, 1'b0);
   endtask

   task automatic do_stop();
      strobe(1'b0, 1'b0);
      strobe(1'b1, 1'b0);
      strobe(1'b1, 1'b1);
   endtask

   task automatic random_read(input int a, input bit full);
      logic r;
      logic [W-1:0] got;
      do_start();
      send_byte(8'hA0);
      send_bit(1'b1, r);
      if (full) check(r == 1'b0, "R5 write-command ack", r, 0);
      send_byte(W'(a));
      send_bit(1'b1, r);
      if (full) check(r == 1'b0, "R6 address ack", r, 0);
      do_start();
      send_byte(8'hA1);
      send_bit(1'b1, r);
      if (full) check(r == 1'b0, "R5 read-command ack", r, 0);
      for (int i = W - 1; i >= 0; i--) begin
         send_bit(1'b1, r);
         got[i] = r;
      end
      check(got == pattern(a), "R7 read byte", got, pattern(a));
      send_bit(1'b1, r);
      if (full) check(r == 1'b0, "R8 final ack", r, 0);
      send_bit(1'b1, r);
      if (full) check(r == 1'b1, "R9 saturated edge", r, 1);
      do_stop();
   endtask

   initial begin
      repeat (CLK_PERIOD * 19000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic r;
      int zeros;
      // R10: preload during reset
      for (int a = 0; a < 256; a++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_addr = W'(a); ld_data = pattern(a);
      end
      @(negedge clk);
      ld_en = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check(sda_rd == 1'b1, "R1 reset level", sda_rd, 1);
      repeat (3) @(negedge clk);
      check(sda_rd == 1'b1, "R1 hold without strobe", sda_rd, 1);

      // R3: no start yet, so no ack ever
      zeros = 0;
      for (int i = 0; i < 10; i++) begin
         send_bit(1'b1, r);
         if (r == 1'b0) zeros++;
      end
      check(zeros == 0, "R3 idle ignores bits", zeros, 0);

      // R11: host level copied on low-clock strobe
      strobe(1'b0, 1'b0);
      check(sda_rd == 1'b0, "R11 copy low", sda_rd, 0);
      strobe(1'b0, 1'b1);
      check(sda_rd == 1'b1, "R11 copy high", sda_rd, 1);

      // R2: stop aborts a partial command
      do_start();
      for (int i = 0; i < 4; i++) send_bit(1'b1, r);
      do_stop();
      zeros = 0;
      for (int i = 0; i < 9; i++) begin
         send_bit(1'b1, r);
         if (r == 1'b0) zeros++;
      end
      check(zeros == 0, "R2 stop returns to idle", zeros, 0);

      // R4: a rising edge with SDA changing is not a bit
      do_start();
      for (int i = 7; i >= 1; i--) send_bit(logic'(8'hA0 >> i), r);
      strobe(1'b1, 1'b1);
      check(sda_rd == 1'b1, "R4 glitch edge copies host", sda_rd, 1);
      strobe(1'b0, 1'b1);
      send_bit(1'b0, r);
      send_bit(1'b1, r);
      check(r == 1'b0, "R4 ack after eight real bits", r, 0);
      do_stop();

      // R5..R9 full sweep over every address
      for (int a = 0; a < 256; a++) random_read(a, (a % 16) == 0);

      // R10: loads outside reset are ignored
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'h42; ld_data = ~pattern(8'h42);
      repeat (2) @(negedge clk);
      ld_en = 1'b0;
      random_read(8'h42, 1'b1);
      check(1'b1, "R10 load outside reset ignored (see R7 read above)", 0, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule